// File: doc/BRIEF.md
# Three-Multiplier Complex Butterfly

This block computes one radix-2 style butterfly on complex fixed-point samples. From three complex inputs `e0`, `e1` and a coefficient `f0`, it produces `o0 = e0*f0 - e1` and `o1 = e0 + e1`. The complex product uses three real multipliers instead of four. Each multiplier is fed by a pre-adder. With `e0 = a + ib` and `f0 = c + id`, the three products are `k1 = c*(a+b)`, `k2 = a*(d-c)` and `k3 = b*(c+d)`. The product's real part is then `k1 - k3` and its imaginary part is `k1 + k2`. The butterfly subtraction of `e1` is folded into the `k1` branch: `Re(o0) = (k1 - Re(e1)) - k3` and `Im(o0) = (k1 - Im(e1)) + k2`.

The unit is fully pipelined in three register stages:
- pre-addition,
- multiplication,
- post-addition.

It accepts a new butterfly on every cycle that carries `inValid` and raises `outValid` three cycles later. All operands are signed 16-bit two's complement. Pre-adder results are 17 bits, products are 34 bits and `o0` is 35 bits wide, so no input pattern can overflow. `o1` is a 17-bit exact sum. The block is intended to sit inside an FFT engine. Twiddle generation, addressing and inter-stage scaling are handled around it.

Top module: `cplx_bfly3`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `outValid` is 0 and all four result ports read 0.
- R2: `o0Re` equals the exact signed value `e0Re*f0Re - e0Im*f0Im - e1Re`, as a 35-bit two's complement number.
- R3: `o0Im` equals the exact signed value `e0Re*f0Im + e0Im*f0Re - e1Im`, as a 35-bit two's complement number.
- R4: `o1Re = e0Re + e1Re` and `o1Im = e0Im + e1Im`, each an exact 17-bit two's complement sum.
- R5: An input sampled with `inValid = 1` at a rising edge produces exactly one cycle of `outValid = 1`, beginning right after the third rising edge from and including the sampling edge. `outValid` is never high without such an input.
- R6: Inputs presented with `inValid` high on consecutive cycles are all accepted. Their results emerge on consecutive cycles in the same order.
- R7: Between results, the four result ports keep the last result. Operand values applied with `inValid = 0` do not change the result ports.
- R8: Full-scale operands, including -32768 on every component, give exact results with no wrap-around in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on this cycle form a butterfly |
| e0Re | input | 16 | Real part of e0, signed |
| e0Im | input | 16 | Imaginary part of e0, signed |
| e1Re | input | 16 | Real part of e1, signed |
| e1Im | input | 16 | Imaginary part of e1, signed |
| f0Re | input | 16 | Real part of coefficient f0, signed |
| f0Im | input | 16 | Imaginary part of coefficient f0, signed |
| outValid | output | 1 | Result ports carry a new butterfly |
| o0Re | output | 35 | Real part of e0*f0 - e1, signed |
| o0Im | output | 35 | Imaginary part of e0*f0 - e1, signed |
| o1Re | output | 17 | Real part of e0 + e1, signed |
| o1Im | output | 17 | Imaginary part of e0 + e1, signed |

## Verification
The arithmetic assertions compare each result against a direct four-product reference. That reference is formed from the operand ports as they stood three edges earlier. The assertions therefore assume the operands hold steady through the sampling edge and that reset does not intervene while a butterfly is in flight. The valid-tracking assertion also assumes `inValid` is low while reset is applied. The stimulus changes operands only on falling edges and keeps `inValid` low throughout reset. It never pulses reset during a test sequence, so every butterfly in flight drains before the next scenario begins.

// File: rtl/cplx_bfly3_pkg.sv
package cplx_bfly3_pkg;

  // Per-stage load strobes from control to datapath
  typedef struct packed {
    logic ldPre;   // capture operands and pre-adder results
    logic ldMul;   // capture the three products
    logic ldOut;   // capture the post-adder results
  } bflyStb_t;

  localparam int unsigned NumStages = 3;

endpackage

// File: rtl/cplx_bfly3_ctrl.sv
module cplx_bfly3_ctrl
  import cplx_bfly3_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output bflyStb_t stb,
  output logic     outValid
);

  logic [NumStages-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[NumStages-2:0], inValid};
  end

  always_comb begin
    stb.ldPre = inValid;
    stb.ldMul = vldPipe[0];
    stb.ldOut = vldPipe[1];
  end

  assign outValid = vldPipe[NumStages-1];

  // R5: no output without an input three edges back
  assert_no_orphan_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));

  // R5: every accepted input yields an output
  assert_no_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid, 3) && $past(rstN, 1) && $past(rstN, 2) && $past(rstN, 3))
      |-> outValid);

endmodule

// File: rtl/cplx_bfly3_datapath.sv
module cplx_bfly3_datapath
  import cplx_bfly3_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bflyStb_t              stb,
  input  logic signed [DW-1:0]  e0Re,
  input  logic signed [DW-1:0]  e0Im,
  input  logic signed [DW-1:0]  e1Re,
  input  logic signed [DW-1:0]  e1Im,
  input  logic signed [DW-1:0]  f0Re,
  input  logic signed [DW-1:0]  f0Im,
  output logic signed [2*DW+2:0] o0Re,
  output logic signed [2*DW+2:0] o0Im,
  output logic signed [DW:0]     o1Re,
  output logic signed [DW:0]     o1Im
);

  localparam int unsigned PAW   = DW + 1;      // pre-adder width
  localparam int unsigned PW    = 2 * DW + 2;  // product width
  localparam int unsigned OW    = 2 * DW + 3;  // post-adder width
  localparam int unsigned SW    = DW + 1;      // direct sum width
  localparam int unsigned NLane = 3;

  // Stage 1: pre-adders
  logic signed [PAW-1:0] preD   [NLane];
  logic signed [DW-1:0]  opD    [NLane];
  logic signed [PAW-1:0] preQ   [NLane];
  logic signed [DW-1:0]  opQ    [NLane];
  logic signed [DW-1:0]  subReS1, subImS1;
  logic signed [SW-1:0]  sumReS1, sumImS1;

  always_comb begin
    // lane 0: c*(a+b)   lane 1: a*(d-c)   lane 2: b*(c+d)
    preD[0] = PAW'(e0Re) + PAW'(e0Im);
    preD[1] = PAW'(f0Im) - PAW'(f0Re);
    preD[2] = PAW'(f0Re) + PAW'(f0Im);
    opD[0]  = f0Re;
    opD[1]  = e0Re;
    opD[2]  = e0Im;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLane; i++) begin
        preQ[i] <= '0;
        opQ[i]  <= '0;
      end
      subReS1 <= '0;
      subImS1 <= '0;
      sumReS1 <= '0;
      sumImS1 <= '0;
    end else if (stb.ldPre) begin
      for (int i = 0; i < NLane; i++) begin
        preQ[i] <= preD[i];
        opQ[i]  <= opD[i];
      end
      subReS1 <= e1Re;
      subImS1 <= e1Im;
      sumReS1 <= SW'(e0Re) + SW'(e1Re);
      sumImS1 <= SW'(e0Im) + SW'(e1Im);
    end
  end

  // Stage 2: three multipliers
  logic signed [PW-1:0] kQ [NLane];
  logic signed [DW-1:0] subReS2, subImS2;
  logic signed [SW-1:0] sumReS2, sumImS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLane; i++) kQ[i] <= '0;
      subReS2 <= '0;
      subImS2 <= '0;
      sumReS2 <= '0;
      sumImS2 <= '0;
    end else if (stb.ldMul) begin
      for (int i = 0; i < NLane; i++) kQ[i] <= PW'(opQ[i]) * PW'(preQ[i]);
      subReS2 <= subReS1;
      subImS2 <= subImS1;
      sumReS2 <= sumReS1;
      sumImS2 <= sumImS1;
    end
  end

  // Stage 3: post-adders with the butterfly subtraction folded into k1
  logic signed [OW-1:0] yRe, xIm;

  always_comb begin
    yRe = OW'(kQ[0]) - OW'(subReS2);
    xIm = OW'(kQ[0]) - OW'(subImS2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      o0Re <= '0;
      o0Im <= '0;
      o1Re <= '0;
      o1Im <= '0;
    end else if (stb.ldOut) begin
      o0Re <= yRe - OW'(kQ[2]);
      o0Im <= xIm + OW'(kQ[1]);
      o1Re <= sumReS2;
      o1Im <= sumImS2;
    end
  end

  // Four-product reference for the assertions
  logic signed [OW-1:0] refRe, refIm;
  logic signed [SW-1:0] refSumRe, refSumIm;

  always_comb begin
    refRe    = OW'(e0Re) * OW'(f0Re) - OW'(e0Im) * OW'(f0Im) - OW'(e1Re);
    refIm    = OW'(e0Re) * OW'(f0Im) + OW'(e0Im) * OW'(f0Re) - OW'(e1Im);
    refSumRe = SW'(e0Re) + SW'(e1Re);
    refSumIm = SW'(e0Im) + SW'(e1Im);
  end

  assert_real_part_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ldOut) |-> (o0Re == $past(refRe, 3)));

  assert_imag_part_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ldOut) |-> (o0Im == $past(refIm, 3)));

  assert_direct_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ldOut) |-> (o1Re == $past(refSumRe, 3) && o1Im == $past(refSumIm, 3)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.ldOut) |-> ($stable(o0Re) && $stable(o0Im) && $stable(o1Re) && $stable(o1Im)));

endmodule

// File: rtl/cplx_bfly3.sv
module cplx_bfly3
  import cplx_bfly3_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [DW-1:0]   e0Re,
  input  logic signed [DW-1:0]   e0Im,
  input  logic signed [DW-1:0]   e1Re,
  input  logic signed [DW-1:0]   e1Im,
  input  logic signed [DW-1:0]   f0Re,
  input  logic signed [DW-1:0]   f0Im,
  output logic                   outValid,
  output logic signed [2*DW+2:0] o0Re,
  output logic signed [2*DW+2:0] o0Im,
  output logic signed [DW:0]     o1Re,
  output logic signed [DW:0]     o1Im
);

  bflyStb_t stb;

  cplx_bfly3_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  cplx_bfly3_datapath #(.DW(DW)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .e0Re (e0Re),
    .e0Im (e0Im),
    .e1Re (e1Re),
    .e1Im (e1Im),
    .f0Re (f0Re),
    .f0Im (f0Im),
    .o0Re (o0Re),
    .o0Im (o0Im),
    .o1Re (o1Re),
    .o1Im (o1Im)
  );

endmodule

// File: tb/cplx_bfly3_tb.sv
`timescale 1ns/1ps
module cplx_bfly3_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] e0Re = '0, e0Im = '0, e1Re = '0, e1Im = '0, f0Re = '0, f0Im = '0;
  logic outValid;
  logic signed [34:0] o0Re, o0Im;
  logic signed [16:0] o1Re, o1Im;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  cplx_bfly3 u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .e0Re(e0Re), .e0Im(e0Im), .e1Re(e1Re), .e1Im(e1Im), .f0Re(f0Re), .f0Im(f0Im),
    .outValid(outValid), .o0Re(o0Re), .o0Im(o0Im), .o1Re(o1Re), .o1Im(o1Im)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  // Expected values for one butterfly
  typedef struct {
    longint re0, im0, re1, im1;
  } exp_t;

  function automatic exp_t model(input longint a, b, c, d, gr, gi);
    exp_t r;
    r.re0 = a * c - b * d - gr;
    r.im0 = a * d + b * c - gi;
    r.re1 = a + gr;
    r.im1 = b + gi;
    return r;
  endfunction

  task automatic checkResult(input exp_t x, input string tag);
    checkEq({tag, " R2 o0Re"}, longint'(o0Re), x.re0);
    checkEq({tag, " R3 o0Im"}, longint'(o0Im), x.im0);
    checkEq({tag, " R4 o1Re"}, longint'(o1Re), x.re1);
    checkEq({tag, " R4 o1Im"}, longint'(o1Im), x.im1);
  endtask

  task automatic setOps(input int a, b, c, d, gr, gi);
    e0Re = 16'(a); e0Im = 16'(b); f0Re = 16'(c); f0Im = 16'(d);
    e1Re = 16'(gr); e1Im = 16'(gi);
  endtask

  // One butterfly, checked on the cycle after the third edge (R5)
  task automatic runOne(input int a, b, c, d, gr, gi, input string tag);
    exp_t x;
    x = model(a, b, c, d, gr, gi);
    @(negedge clk);
    setOps(a, b, c, d, gr, gi);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkEq({tag, " R5 no early valid"}, longint'(outValid), 0);
    @(negedge clk);
    checkEq({tag, " R5 no early valid"}, longint'(outValid), 0);
    @(negedge clk);
    checkEq({tag, " R5 valid at latency 3"}, longint'(outValid), 1);
    checkResult(x, tag);
    @(negedge clk);
    checkEq({tag, " R5 single pulse"}, longint'(outValid), 0);
  endtask

  task automatic testReset();
    checkEq("R1 outValid in reset", longint'(outValid), 0);
    checkEq("R1 o0Re in reset", longint'(o0Re), 0);
    checkEq("R1 o1Im in reset", longint'(o1Im), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 outValid after reset", longint'(outValid), 0);
    checkEq("R1 o0Im after reset", longint'(o0Im), 0);
    checkEq("R1 o1Re after reset", longint'(o1Re), 0);
  endtask

  task automatic testBasic();
    runOne(3, 4, 5, -2, 1, 7, "basic1");
    runOne(-1200, 350, 77, 9000, -5, 31000, "basic2");
    runOne(0, 0, 12345, -321, 100, -100, "zeroE0");
    runOne(1, 0, -7, 11, 0, 0, "unitE0");
  endtask

  task automatic testExtremes();
    runOne(-32768, -32768, -32768, -32768, 32767, 32767, "R8 allMin");
    runOne(-32768, 32767, -32768, -32768, -32768, -32768, "R8 mixA");
    runOne(32767, -32768, 32767, -32768, -32768, 32767, "R8 mixB");
    runOne(32767, 32767, 32767, 32767, -32768, -32768, "R8 allMax");
  endtask

  task automatic testBackToBack();
    localparam int N = 6;
    int va[N] = '{100, -32768, 7, 32767, -1, 2000};
    int vb[N] = '{-50, 32767, -9, 32767, -1, 3};
    int vc[N] = '{3, -32768, 1000, -32768, -1, -4000};
    int vd[N] = '{4, 12, -1000, 32767, 1, 5};
    int vg[N] = '{1, 2, -32768, 4, 32767, 6};
    int vh[N] = '{-1, -2, 3, -32768, 5, 32767};
    for (int cyc = 0; cyc < N + 3; cyc++) begin
      @(negedge clk);
      if (cyc >= 3) begin
        checkEq("R6 valid on stream", longint'(outValid), 1);
        checkResult(model(va[cyc-3], vb[cyc-3], vc[cyc-3], vd[cyc-3], vg[cyc-3], vh[cyc-3]), "R6 stream");
      end
      if (cyc < N) begin
        setOps(va[cyc], vb[cyc], vc[cyc], vd[cyc], vg[cyc], vh[cyc]);
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    checkEq("R6 stream ends", longint'(outValid), 0);
  endtask

  task automatic testHold();
    exp_t x;
    runOne(-900, 444, 123, -456, 789, -1011, "holdSeed");
    x = model(-900, 444, 123, -456, 789, -1011);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      setOps(32767 - i * 1000, -32768 + i, i * 77, -i * 55, i, -i);
      checkEq("R7 idle no valid", longint'(outValid), 0);
      checkResult(x, "R7 hold");
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #20000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testBasic();
    testExtremes();
    testBackToBack();
    testHold();
    repeat (2) @(negedge clk);
    finish();
  end

endmodule